// File: doc/BRIEF.md
# Free-Running Compare Interval Timer

This block is an up-counting timer with one compare register and one interrupt pulse output. Software starts and stops it through a small strobe-based register interface. While it runs, the counter steps by one on every clock, passes through all ones back to zero and keeps going. It never reloads on a match. Each time the count equals the compare value, the block emits a one-clock interrupt pulse. The compare value may be rewritten while the counter runs.

A control register holds a mode bit, which must select free-running compare operation before a start is accepted, and a start-interrupt bit. When the start-interrupt bit is set, the block also emits a pulse at the moment counting begins. A stop freezes the count so that software can read it. Every start, including a start while the counter is already running, begins again from zero. The counter width is a parameter (`CNT_W`, default 32), and the data bus has the same width.

Register map (`addr`): 0x0 control, 0x1 compare, 0x2 count (read-only), 0x3 status (read-only), 0x4 trigger (write-only).

Top module: `cmp_timer`

## Requirements
- R1: While running, the count increases by exactly one on every clock. Counting is allowed only when control bit 0 (free-running compare mode, address 0x0) is 1 at the start.
- R2: When the count equals the compare value while running, `irq` is high for one clock in the cycle after that clock edge. No other condition produces a match pulse.
- R3: The compare register (address 0x1) can be written at any time, including while running. Matching uses the new value from the cycle after the write.
- R4: Writing 1 to trigger bit 0 (address 0x4) starts counting. Status bit 0 (address 0x3) then reads 1.
- R5: Every accepted start loads the count with zero, including a start while the counter is already running.
- R6: Writing 1 to trigger bit 1 stops counting and clears status bit 0. If bits 0 and 1 are written together, the stop wins and no start takes place.
- R7: A stopped counter holds its value (readable at address 0x2) and produces no match pulses, even when the held value equals the compare value.
- R8: After all ones, the count wraps to zero and keeps running with no pulse at the wrap. A match therefore recurs once per 2^CNT_W clocks.
- R9: Writes to the control register while running are ignored. Writes while stopped take effect.
- R10: When control bit 1 (start interrupt) is 1, an accepted start produces a pulse in the following cycle. If a match occurs on the same edge as the start, only a single one-clock pulse results.
- R11: A start written while control bit 0 is 0 is ignored, and the counter stays stopped.
- R12: After reset, all registers read 0 and `irq` is 0. The trigger register always reads 0. Read data appears on `rdata` one clock after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one register |
| rd_en | input | 1 | Read strobe; `rdata` is loaded on this edge |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data |
| irq | output | 1 | One-clock interrupt pulse |

## Verification
Let E0 be the clock edge that accepts a start, and let C be the compare value. The count holds k after edge Ek, so a match pulse is due in the cycle after edge E(C+1), and the start pulse is due in the cycle after E0. A monitor samples `irq` two nanoseconds after each rising edge and logs the pulse index k relative to E0, and the checks compare these index lists exactly. Register reads are sampled at the falling edge after the edge that captured `rd_en`, so a count read issued right after a start returns 0. The wrap checks run with an 8-bit counter, so the 256-clock repeat period fits within the run.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CMP   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TRIG  = 3'd4;

  localparam int TRIG_START_BIT = 0;
  localparam int TRIG_STOP_BIT  = 1;

  typedef struct packed {
    logic start_irq;  // bit 1
    logic free_mode;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              running,
  input  logic [CNT_W-1:0]  count,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  cmp_val,
  output logic              start_req,
  output logic              stop_req,
  output logic [CNT_W-1:0]  rdata
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic             wr_trig;
  logic [CNT_W-1:0] rd_mux;

  assign wr_trig   = wr_en && (addr == ADR_TRIG);
  assign stop_req  = wr_trig && wdata[TRIG_STOP_BIT];
  assign start_req = wr_trig && wdata[TRIG_START_BIT] && !wdata[TRIG_STOP_BIT]
                     && ctrl.free_mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      cmp_val <= '0;
    end else if (wr_en) begin
      if (addr == ADR_CTRL && !running) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == ADR_CMP) cmp_val <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      ADR_CTRL:  rd_mux[CTRL_W-1:0] = ctrl;
      ADR_CMP:   rd_mux = cmp_val;
      ADR_COUNT: rd_mux = count;
      ADR_STAT:  rd_mux[0] = running;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             stop_req,
  output logic             running,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      count   <= '0;
    end else if (stop_req) begin
      running <= 1'b0;
    end else if (start_req) begin
      running <= 1'b1;
      count   <= '0;
    end else if (running) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             running,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             start_req,
  input  logic             start_irq_en,
  output logic             irq
);
  logic match_hit;
  logic start_hit;

  assign match_hit = running && (count == cmp_val);
  assign start_hit = start_req && start_irq_en;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= match_hit || start_hit;
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cmp_val;
  logic [CNT_W-1:0] count;
  logic             running;
  logic             start_req;
  logic             stop_req;

  cmp_timer_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .running   (running),
    .count     (count),
    .ctrl      (ctrl),
    .cmp_val   (cmp_val),
    .start_req (start_req),
    .stop_req  (stop_req),
    .rdata     (rdata)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .stop_req  (stop_req),
    .running   (running),
    .count     (count)
  );

  cmp_timer_irq #(.CNT_W(CNT_W)) u_irq (
    .clk          (clk),
    .rst          (rst),
    .running      (running),
    .count        (count),
    .cmp_val      (cmp_val),
    .start_req    (start_req),
    .start_irq_en (ctrl.start_irq),
    .irq          (irq)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             running,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp_val,
  input logic             start_req,
  input logic             stop_req,
  input logic             free_mode,
  input logic             start_irq,
  input logic             irq
);
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(start_req) |-> running && count == '0);  // R5
  AST_STOP_HALTS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(stop_req) |-> !running);  // R6
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(running) && !$past(start_req) |-> count == $past(count));  // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(running) && !$past(start_req) && !$past(stop_req)
    |-> count == CNT_W'($past(count) + 1'b1));  // R1
  AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(running) && $past(count) == $past(cmp_val) |-> irq);  // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && irq |-> ($past(running) && $past(count) == $past(cmp_val))
                           || ($past(start_req) && $past(start_irq)));  // R10
  AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(running)
    |-> free_mode == $past(free_mode) && start_irq == $past(start_irq));  // R9
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .running   (running),
  .count     (count),
  .cmp_val   (cmp_val),
  .start_req (start_req),
  .stop_req  (stop_req),
  .free_mode (ctrl.free_mode),
  .start_irq (ctrl.start_irq),
  .irq       (irq)
);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  localparam int TW = 8;
  localparam logic [2:0] A_CTRL = 3'd0, A_CMP = 3'd1, A_CNT = 3'd2,
                         A_STAT = 3'd3, A_TRIG = 3'd4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [2:0]    addr = '0;
  logic [TW-1:0] wdata = '0;
  logic [TW-1:0] rdata;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  int edge_cnt = 0;
  int start_edge = 0;
  int npulse = 0;
  int pulse_k [0:15];

  always #4 clk = ~clk;  // 125 MHz

  cmp_timer #(.CNT_W(TW)) i_cmp_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Pulse monitor: samples irq 2 ns after each rising edge.
  always begin
    @(posedge clk);
    edge_cnt = edge_cnt + 1;
    #2;
    if (irq === 1'b1 && npulse < 16) begin
      pulse_k[npulse] = edge_cnt - start_edge;
      npulse = npulse + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All bus tasks are entered at a falling edge and return at a falling edge.
  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; addr = a; wdata = TW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  task automatic start_timer();
    start_edge = edge_cnt + 1;
    npulse = 0;
    wr(A_TRIG, 1);
  endtask

  task automatic stop_timer();
    wr(A_TRIG, 2);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    check(irq === 1'b0, "R12 irq after reset", int'(irq), 0);
    rd(A_CTRL, v);  check(v == 0, "R12 ctrl after reset", v, 0);
    rd(A_CMP, v);   check(v == 0, "R12 cmp after reset", v, 0);
    rd(A_CNT, v);   check(v == 0, "R12 count after reset", v, 0);
    rd(A_STAT, v);  check(v == 0, "R12 status after reset", v, 0);
  endtask

  task automatic t_mode_off();
    int v;
    start_timer();
    idle(3);
    rd(A_STAT, v); check(v == 0, "R11 start ignored with mode 0", v, 0);
    rd(A_CNT, v);  check(v == 0, "R11 count stays 0", v, 0);
  endtask

  task automatic t_basic();
    int v;
    wr(A_CTRL, 1);
    wr(A_CMP, 5);
    start_timer();
    rd(A_STAT, v); check(v == 1, "R4 status running", v, 1);
    rd(A_TRIG, v); check(v == 0, "R12 trigger reads 0", v, 0);
    idle(20);
    check(npulse == 1, "R2 single match pulse", npulse, 1);
    check(pulse_k[0] == 6, "R2 match pulse timing", pulse_k[0], 6);
    wr(A_CTRL, 3);
    rd(A_CTRL, v); check(v == 1, "R9 ctrl write ignored while running", v, 1);
  endtask

  task automatic t_stop_hold();
    int v1, v2;
    stop_timer();
    rd(A_STAT, v1); check(v1 == 0, "R6 status cleared by stop", v1, 0);
    rd(A_CNT, v1);
    idle(10);
    rd(A_CNT, v2); check(v1 == v2 && v1 != 0, "R7 count held after stop", v2, v1);
    npulse = 0;
    wr(A_CMP, v1);
    idle(10);
    check(npulse == 0, "R7 no pulse while stopped at match value", npulse, 0);
    rd(A_CNT, v2); check(v2 == v1, "R7 count still held", v2, v1);
  endtask

  task automatic t_restart_irq();
    int v;
    wr(A_CTRL, 3);
    rd(A_CTRL, v); check(v == 3, "R9 ctrl write while stopped", v, 3);
    wr(A_CMP, 10);
    start_timer();
    rd(A_CNT, v); check(v == 0, "R5 restart from zero", v, 0);
    idle(20);
    check(npulse == 2, "R10 start plus match pulses", npulse, 2);
    check(pulse_k[0] == 0, "R10 start pulse timing", pulse_k[0], 0);
    check(pulse_k[1] == 11, "R1 match after counting", pulse_k[1], 11);
  endtask

  task automatic t_cmp_rewrite();
    wr(A_CTRL, 1);  // ignored: still running with ctrl=3
    stop_timer();
    wr(A_CTRL, 1);
    wr(A_CMP, 250);
    start_timer();
    wr(A_CMP, 20);   // applied on edge k=1, count 1
    idle(40);
    check(npulse == 1, "R3 one pulse after compare rewrite", npulse, 1);
    check(pulse_k[0] == 21, "R3 pulse uses new compare", pulse_k[0], 21);
  endtask

  task automatic t_coincide();
    stop_timer();
    wr(A_CTRL, 3);
    wr(A_CMP, 5);
    start_timer();      // now after E0
    idle(5);            // after E5
    wr(A_TRIG, 1);      // restart applied on E6 while count == 5
    idle(20);
    check(npulse == 3, "R10 coincident start and match give one pulse", npulse, 3);
    check(pulse_k[1] == 6, "R10 merged pulse timing", pulse_k[1], 6);
    check(pulse_k[2] == 12, "R5 restart while running from zero", pulse_k[2], 12);
  endtask

  task automatic t_stop_priority();
    int v1, v2;
    wr(A_TRIG, 3);
    rd(A_STAT, v1); check(v1 == 0, "R6 stop wins over start", v1, 0);
    rd(A_CNT, v1);
    wr(A_TRIG, 3);
    idle(3);
    rd(A_CNT, v2); check(v2 == v1, "R6 both triggers while stopped keep count", v2, v1);
  endtask

  task automatic t_wrap();
    wr(A_CTRL, 1);
    wr(A_CMP, 3);
    start_timer();
    idle(600);
    check(npulse == 3, "R8 one pulse per wrap period", npulse, 3);
    check(pulse_k[1] == 4 + (1 << TW), "R8 second match after wrap", pulse_k[1], 4 + (1 << TW));
    check(pulse_k[2] == 4 + 2 * (1 << TW), "R8 third match after wrap", pulse_k[2], 4 + 2 * (1 << TW));
    stop_timer();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mode_off();
    t_basic();
    t_stop_hold();
    t_restart_irq();
    t_cmp_rewrite();
    t_coincide();
    t_stop_priority();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule